// File: doc/BRIEF.md
# Remainder-Based Binary Multiplier

This block multiplies two unsigned N-bit operands by treating each one as an offset from the midpoint base 2^(N-1). Each operand's top bit decides the offset's direction. When the top bit is set, the offset is positive and equals the lower N-1 bits. When it is clear, the offset is negative and its magnitude is the base minus those lower bits. A smaller internal multiplier forms the product of the two offset magnitudes. That product is then combined with two shifted terms: operand A scaled by the base, and B's offset magnitude scaled by the base. Each term is added or subtracted according to the operand top bits. One combined datapath covers every mix of offsets, and the operands are never exchanged.

A parameter chooses between two output styles. The registered style captures the product into a register, and its valid flag follows the input valid one cycle later. The combinational style presents the product in the same cycle. A second parameter chooses how the internal offset multiplier is built: either as a plain operator or as an unrolled array of shifted partial products.

Top module: `rbm_multiplier`

## Requirements
- R1: For every operand pair, the product output equals A·B as an unsigned 2N-bit value.
- R2: An operand with top bit 1 contributes a positive offset equal to its lower N-1 bits.
- R3: An operand with top bit 0 contributes a negative offset of magnitude 2^(N-1) minus its lower N-1 bits. This magnitude is carried in N bits.
- R4: The base-scaled offset term of B is added when B ≥ 2^(N-1) and subtracted when B < 2^(N-1).
- R5: The product of the offset magnitudes is subtracted when the two operand top bits differ, and added when they match.
- R6: Operands are never exchanged. The result is correct whether A < B or A > B.
- R7: When either operand is 0, the product is 0. This covers the 2^(N-1) offset magnitude of a zero operand.
- R8: With OUT_REG=1, valid_out is high exactly one cycle after valid_in is high. The product output then holds the product of the operands presented in that cycle.
- R9: With OUT_REG=1, a cycle with valid_in low leaves the product output unchanged and drives valid_out low in the next cycle, whatever the operand values.
- R10: With OUT_REG=1, a synchronous active-high reset clears both valid_out and the product output to 0.
- R11: With OUT_REG=0, the product output and valid_out follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands on a and b are valid |
| a | input | N | Unsigned operand A |
| b | input | N | Unsigned operand B |
| valid_out | output | 1 | Product output is valid |
| p | output | 2N | Unsigned product A·B |

## Verification
The assertions on offset magnitudes and on zero operands are evaluated only in cycles where valid_in is high. They assume that the operands are fully driven, known values in those cycles. The bench keeps to this by holding reset until every input has been set. It also keeps valid_in low whenever the operands are deliberately changed to test that they are ignored. An 8-bit registered instance is swept over every operand pair, one pair per cycle. A 16-bit combinational instance gets the corner values 0, 2^15-1, 2^15 and 2^16-1 on each operand, followed by random pairs.

// File: rtl/rbm_pkg.sv
`timescale 1ns/1ps
package rbm_pkg;

  // Direction in which a term enters the final sum.
  typedef enum logic {
    TERM_ADD = 1'b0,
    TERM_SUB = 1'b1
  } term_op_e;

  // Add or subtract a term, modulo the width of the operands.
  function automatic logic [127:0] add_sub(input logic [127:0] acc,
                                           input logic [127:0] term,
                                           input term_op_e     op);
    return (op == TERM_SUB) ? (acc - term) : (acc + term);
  endfunction

endpackage

// File: rtl/rbm_remainder.sv
`timescale 1ns/1ps
module rbm_remainder
  import rbm_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] opnd,
  output logic [N-1:0] mag,
  output term_op_e     dir
);
  localparam int unsigned H = N - 1;
  localparam logic [N-1:0] BASE = {1'b1, {H{1'b0}}};

  logic [N-1:0] low_ext;
  logic [N-1:0] neg_mag;

  assign low_ext = {1'b0, opnd[H-1:0]};
  // The N-bit width keeps the full base for a zero operand.
  assign neg_mag = BASE - low_ext;

  // Steering multiplexer driven by the operand's top bit.
  always_comb begin
    if (opnd[H]) begin
      mag = low_ext;
      dir = TERM_ADD;
    end else begin
      mag = neg_mag;
      dir = TERM_SUB;
    end
  end

endmodule

// File: rtl/rbm_core_mult.sv
`timescale 1ns/1ps
module rbm_core_mult #(
  parameter int unsigned W     = 16,
  parameter int unsigned STYLE = 0
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;

  generate
    if (STYLE == 0) begin : g_operator
      assign prod = PW'(x) * PW'(y);
    end else begin : g_array
      logic [PW-1:0] pp  [W];
      logic [PW-1:0] acc [W+1];
      assign acc[0] = '0;
      for (genvar g = 0; g < W; g++) begin : g_row
        assign pp[g]    = y[g] ? (PW'(x) << g) : '0;
        assign acc[g+1] = acc[g] + pp[g];
      end
      assign prod = acc[W];
    end
  endgenerate

endmodule

// File: rtl/rbm_combine.sv
`timescale 1ns/1ps
module rbm_combine
  import rbm_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   rem_b,
  input  logic [2*N-1:0] rem_prod,
  input  term_op_e       b_op,
  input  term_op_e       p_op,
  output logic [2*N-1:0] prod
);
  localparam int unsigned H  = N - 1;
  localparam int unsigned AW = 2 * N;

  logic [AW-1:0] t_base;
  logic [AW-1:0] t_rb;
  logic [AW-1:0] s1;
  logic [AW-1:0] s2;
  logic [127:0]  w1;
  logic [127:0]  w2;

  assign t_base = AW'(a) << H;
  assign t_rb   = AW'(rem_b) << H;

  assign w1 = add_sub(128'(t_base), 128'(t_rb), b_op);
  assign s1 = w1[AW-1:0];
  assign w2 = add_sub(128'(s1), 128'(rem_prod), p_op);
  assign s2 = w2[AW-1:0];

  assign prod = s2;

  // Upper bits of the wide helper results are discarded modulo 2^AW.
  logic unused_hi;
  assign unused_hi = ^{w1[127:AW], w2[127:AW]};

endmodule

// File: rtl/rbm_multiplier.sv
`timescale 1ns/1ps
module rbm_multiplier
  import rbm_pkg::*;
#(
  parameter int unsigned N          = 16,
  parameter int unsigned OUT_REG    = 1,
  parameter int unsigned MULT_STYLE = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_in,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           valid_out,
  output logic [2*N-1:0] p
);
  localparam int unsigned H  = N - 1;
  localparam int unsigned PW = 2 * N;
  localparam logic [N-1:0] BASE = {1'b1, {H{1'b0}}};

  logic [N-1:0]  rem_a;
  logic [N-1:0]  rem_b;
  term_op_e      dir_a;
  term_op_e      dir_b;
  term_op_e      p_op;
  logic [PW-1:0] rem_prod;
  logic [PW-1:0] prod_c;

  rbm_remainder #(.N(N)) u_rem_a (.opnd(a), .mag(rem_a), .dir(dir_a));
  rbm_remainder #(.N(N)) u_rem_b (.opnd(b), .mag(rem_b), .dir(dir_b));

  // Offset product enters negatively only when the offsets disagree in sign.
  assign p_op = term_op_e'(dir_a ^ dir_b);

  rbm_core_mult #(.W(N), .STYLE(MULT_STYLE)) u_core (
    .x(rem_a), .y(rem_b), .prod(rem_prod)
  );

  rbm_combine #(.N(N)) u_comb (
    .a(a), .rem_b(rem_b), .rem_prod(rem_prod),
    .b_op(dir_b), .p_op(p_op), .prod(prod_c)
  );

  AST_REM_POS: assert property (@(posedge clk) disable iff (rst)
    (valid_in && a[H]) |-> (rem_a < BASE)); // R2
  AST_REM_NEG: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !a[H]) |-> ((rem_a + {1'b0, a[H-1:0]}) == BASE)); // R3
  AST_ZERO_OPND: assert property (@(posedge clk) disable iff (rst)
    (valid_in && (a == '0 || b == '0)) |-> (prod_c == '0)); // R7
  AST_BASE_OPND: assert property (@(posedge clk) disable iff (rst)
    (valid_in && a == BASE) |-> (prod_c == (PW'(b) << H))); // R1

  generate
    if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_out <= 1'b0;
          p         <= '0;
        end else begin
          valid_out <= valid_in;
          if (valid_in) p <= prod_c;
        end
      end

      AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out); // R8
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> (!valid_out && $stable(p))); // R9
      AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (!valid_out && p == '0)); // R10
    end else begin : g_comb
      assign valid_out = valid_in;
      assign p         = prod_c;
    end
  endgenerate

endmodule

// File: tb/test_rbm_multiplier.sv
`timescale 1ns/1ps
module test_rbm_multiplier;
  localparam int unsigned NA = 8;
  localparam int unsigned NB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic            v8 = 1'b0;
  logic [NA-1:0]   a8 = '0, b8 = '0;
  logic            vo8;
  logic [2*NA-1:0] p8;

  logic            v16 = 1'b0;
  logic [NB-1:0]   a16 = '0, b16 = '0;
  logic            vo16;
  logic [2*NB-1:0] p16;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  rbm_multiplier #(.N(NA), .OUT_REG(1), .MULT_STYLE(1)) i_rbm_multiplier (
    .clk(clk), .rst(rst), .valid_in(v8), .a(a8), .b(b8),
    .valid_out(vo8), .p(p8)
  );

  rbm_multiplier #(.N(NB), .OUT_REG(0), .MULT_STYLE(0)) i_rbm_multiplier_w (
    .clk(clk), .rst(rst), .valid_in(v16), .a(a16), .b(b16),
    .valid_out(vo16), .p(p16)
  );

  task automatic check(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag8(input int ia, input int ib);
    if (ia == 0 || ib == 0) return "R7";
    if (ia >= 128 && ib >= 128) return "R2";
    if (ia < 128 && ib < 128) return "R3";
    return "R5";
  endfunction

  task automatic check16(input int ia, input int ib, input string req);
    longint unsigned e;
    @(negedge clk);
    a16 = NB'(ia); b16 = NB'(ib); v16 = 1'b1;
    #1;
    e = longint'(ia) * longint'(ib);
    check(p16 == 32'(e), req, p16, e);
    check(vo16 == 1'b1, "R11 valid", vo16, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(vo8 == 1'b0, "R10 reset valid", vo8, 0);
    check(p8 == '0, "R10 reset product", p8, 0);
    rst = 1'b0;

    // R8: one-cycle latency
    a8 = 8'd200; b8 = 8'd3; v8 = 1'b1;
    @(negedge clk);
    check(vo8 == 1'b1, "R8 valid", vo8, 1);
    check(p8 == 16'd600, "R8 product", p8, 600);
    // R9: changed operands with valid low are ignored
    a8 = 8'd5; b8 = 8'd5; v8 = 1'b0;
    @(negedge clk);
    check(vo8 == 1'b0, "R9 valid", vo8, 0);
    check(p8 == 16'd600, "R9 hold", p8, 600);
    // R10: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check(vo8 == 1'b0, "R10 mid valid", vo8, 0);
    check(p8 == '0, "R10 mid product", p8, 0);
    rst = 1'b0;

    // R1: exhaustive sweep, one pair per cycle
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        a8 = NA'(ia); b8 = NA'(ib); v8 = 1'b1;
        @(negedge clk);
        check(p8 == 16'(ia * ib) && vo8, {"R1 ", tag8(ia, ib)}, p8, ia * ib);
      end
    end
    v8 = 1'b0;

    // R11 and R1 on the wide combinational instance
    @(negedge clk);
    v16 = 1'b0; a16 = 16'd7; b16 = 16'd9;
    #1;
    check(vo16 == 1'b0, "R11 idle valid", vo16, 0);
    check(p16 == 32'd63, "R11 same-cycle product", p16, 63);
    begin
      int cv [4] = '{0, 32'h7FFF, 32'h8000, 32'hFFFF};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          check16(cv[i], cv[j], (cv[i] == 0 || cv[j] == 0) ? "R7 corner" : "R1 corner");
    end
    check16(40000, 1000, "R4 B below base");
    check16(40000, 50000, "R4 B above base");
    check16(3, 65000, "R6 A<B");
    check16(65000, 3, "R6 A>B");
    check16(100, 60000, "R5 mixed");
    check16(32768, 12345, "R2 A at base");
    check16(1, 1, "R3 both low");
    for (int k = 0; k < 2000; k++)
      check16(int'($urandom_range(65535)), int'($urandom_range(65535)), "R1 random");
    v16 = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule